// File: doc/BRIEF.md
# Scan-Path Control State Machine

This block is a five-state Mealy control machine whose state is held in three binary-coded flip-flops. A single mode input chooses what those flip-flops do on each rising clock edge. In run mode they take the next state computed from the current state and three condition inputs, and the machine drives five action outputs. In scan mode the same flip-flops form a three-bit serial shift chain fed from a test input. A tester can then place the machine in any state code, legal or not, in three clock cycles. No synchronizing input sequence is needed.

The action outputs are a combinational function of the current state and the condition inputs. They stay live while the chain shifts, so the effect of a loaded state can be seen at once. An unused state code is left on the next run-mode edge, towards the start state, with no action asserted.

Top module: `scanpath_ctl_fsm`

## Requirements
- R1: A low `rst_n` at a rising clock edge puts the machine in the start state (code 001), whatever `run_en` and `scan_in` are. While in that state with `run_en` high, the next edge enters the branch state.
- R2: The states are coded in binary: start 001, branch 010, pass 011, decide 100, return 101. A code loaded through the scan chain behaves as that state.
- R3: While `run_en` is 1, each rising edge loads the next state given by R5 to R10, and no other value.
- R4: While `run_en` is 0, each rising edge shifts the state one place toward bit 2. Bit 2 is dropped, and `scan_in` enters bit 0.
- R5: In the start state, `act_o[0]` and `act_o[1]` are asserted and the next state is branch. The condition inputs have no effect in this state.
- R6: In the branch state, if `sel_branch` is 1 then `act_o[3]` is asserted and the next state is decide. Otherwise `act_o[2]` is asserted and the next state is pass.
- R7: In the pass state, no action is asserted and the next state is return.
- R8: In the decide state, `req_back` has top priority: it asserts `act_o[3]` and `act_o[4]`, and the next state is pass. If only `req_stay` is 1, no action is asserted and the state holds. If neither is 1, `act_o[2]` is asserted and the next state is return.
- R9: In the return state, `act_o[4]` is asserted and the next state is start.
- R10: The codes 000, 110 and 111 assert no action, and they move to the start state on the next run-mode edge.
- R11: `act_o` follows the current state and the condition inputs with no clock delay. It is not forced low while `run_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | 1: load the computed next state; 0: shift the scan chain |
| scan_in | input | 1 | Serial test bit shifted into state bit 0 |
| sel_branch | input | 1 | Branch-state condition |
| req_back | input | 1 | Decide-state condition, top priority |
| req_stay | input | 1 | Decide-state hold condition |
| act_o | output | 5 | Mealy action outputs, bit 0 first |

## Verification
The actions are due in the same cycle as the state and inputs that produce them. The bench changes inputs just after a rising edge and compares `act_o` at the following falling edge. A state change made by a run-mode edge only shows one edge later, through the actions of the new state. So each table row checks the actions right after the scan load, then drives fixed probe inputs and checks at the next two falling edges. A scan load takes three edges with the most significant bit first, and the bench compares nothing until the third edge has passed.

// File: rtl/scanfsm_pkg.sv
// Package: shared widths, state codes and action bit positions for the
// scan-path control machine. Assumes binary state coding in ST_W bits.
package scanfsm_pkg;

    localparam int ST_W  = 3;
    localparam int ACT_W = 5;

    typedef logic [ST_W-1:0]  state_t;
    typedef logic [ACT_W-1:0] act_t;

    // State codes; scan loading depends on these exact values.
    localparam state_t ST_START  = 3'b001;
    localparam state_t ST_BRANCH = 3'b010;
    localparam state_t ST_PASS   = 3'b011;
    localparam state_t ST_DECIDE = 3'b100;
    localparam state_t ST_RETURN = 3'b101;

    // Action bit positions within act_t.
    localparam int ACT_P0 = 0;
    localparam int ACT_P1 = 1;
    localparam int ACT_P2 = 2;
    localparam int ACT_P3 = 3;
    localparam int ACT_P4 = 4;

    // True for one of the five defined state codes.
    function automatic logic is_legal(input state_t s);
        return (s == ST_START) || (s == ST_BRANCH) || (s == ST_PASS) ||
               (s == ST_DECIDE) || (s == ST_RETURN);
    endfunction

endpackage

// File: rtl/ctl_next_state.sv
// Next-state logic for run mode. Purely combinational; maps every code,
// including the unused ones, to a defined state. Assumes the binary coding
// from scanfsm_pkg.
module ctl_next_state
    import scanfsm_pkg::*;
(
    input  state_t state,
    input  logic   sel_branch,
    input  logic   req_back,
    input  logic   req_stay,
    output state_t nxt
);

    // Transition table; req_back outranks req_stay in the decide state.
    always_comb begin
        unique case (state)
            ST_START:  nxt = ST_BRANCH;
            ST_BRANCH: nxt = sel_branch ? ST_DECIDE : ST_PASS;
            ST_PASS:   nxt = ST_RETURN;
            ST_DECIDE: begin
                if (req_back)      nxt = ST_PASS;
                else if (req_stay) nxt = ST_DECIDE;
                else               nxt = ST_RETURN;
            end
            ST_RETURN: nxt = ST_START;
            default:   nxt = ST_START;
        endcase
    end

endmodule

// File: rtl/ctl_mealy_out.sv
// Mealy action decoder. Combinational from the current state and the
// condition inputs; does not look at the mode, so actions stay live while
// the scan chain shifts. Unused codes decode to no action.
module ctl_mealy_out
    import scanfsm_pkg::*;
(
    input  state_t state,
    input  logic   sel_branch,
    input  logic   req_back,
    input  logic   req_stay,
    output act_t   act
);

    // Arc actions; any bit not named by an arc stays 0.
    always_comb begin
        act = '0;
        unique case (state)
            ST_START: begin
                act[ACT_P0] = 1'b1;
                act[ACT_P1] = 1'b1;
            end
            ST_BRANCH: begin
                if (sel_branch) act[ACT_P3] = 1'b1;
                else            act[ACT_P2] = 1'b1;
            end
            ST_PASS: act = '0;
            ST_DECIDE: begin
                if (req_back) begin
                    act[ACT_P3] = 1'b1;
                    act[ACT_P4] = 1'b1;
                end else if (!req_stay) begin
                    act[ACT_P2] = 1'b1;
                end
            end
            ST_RETURN: act[ACT_P4] = 1'b1;
            default:   act = '0;
        endcase
    end

endmodule

// File: rtl/ctl_state_reg.sv
// State register with a scan multiplexer in front of each flip-flop.
// run_en=1 loads the computed next state; run_en=0 shifts toward the MSB,
// with scan_in entering bit 0. Synchronous active-low reset to RST_VAL.
module ctl_state_reg #(
    parameter int                 W       = 3,
    parameter logic [W-1:0]       RST_VAL = 3'b001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         scan_in,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] state_q
);

    logic [W-1:0] shift_v;
    logic [W-1:0] d;

    // Per-bit shift source: bit 0 from the test input, others from below.
    for (genvar b = 0; b < W; b++) begin : g_chain
        if (b == 0) begin : g_head
            assign shift_v[b] = scan_in;
        end else begin : g_link
            assign shift_v[b] = state_q[b-1];
        end
    end

    // Mode multiplexer in front of the flip-flops.
    assign d = run_en ? nxt : shift_v;

    // State flip-flops with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_VAL;
        else        state_q <= d;
    end

    AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_en)) |->
        (state_q == {$past(state_q[W-2:0]), $past(scan_in)}));  // R4

    AST_RUN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en)) |-> (state_q == $past(nxt)));  // R3

endmodule

// File: rtl/scanpath_ctl_fsm.sv
// Top: five-state Mealy control machine with a scannable state register.
// Assumes one clock domain and a synchronous active-low reset; the tester
// drives run_en low to shift a state code in MSB first.
module scanpath_ctl_fsm
    import scanfsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             scan_in,
    input  logic             sel_branch,
    input  logic             req_back,
    input  logic             req_stay,
    output logic [ACT_W-1:0] act_o
);

    state_t state;
    state_t nxt;
    act_t   act;

    // Run-mode transition logic.
    ctl_next_state i_next (
        .state      (state),
        .sel_branch (sel_branch),
        .req_back   (req_back),
        .req_stay   (req_stay),
        .nxt        (nxt)
    );

    // Scannable state register.
    ctl_state_reg #(
        .W       (ST_W),
        .RST_VAL (ST_START)
    ) i_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .scan_in (scan_in),
        .nxt     (nxt),
        .state_q (state)
    );

    // Mealy action decode.
    ctl_mealy_out i_out (
        .state      (state),
        .sel_branch (sel_branch),
        .req_back   (req_back),
        .req_stay   (req_stay),
        .act        (act)
    );

    assign act_o = act;

    AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == ST_START));  // R1

    AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && !is_legal($past(state))) |->
        (state == ST_START));  // R10

    AST_PASS_TO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_PASS) |=> (state == ST_RETURN));  // R7

    AST_RETURN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_RETURN) |=> (state == ST_START));  // R9

    AST_START_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_START) |=> (state == ST_BRANCH));  // R5

endmodule

// File: tb/test_scanpath_ctl_fsm.sv
// Bench: table of scan-loaded start codes, inputs and expected actions,
// then directed tests for reset, shifting and recovery.
module test_scanpath_ctl_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b1;
    logic       scan_in = 1'b0;
    logic       sel_branch = 1'b0;
    logic       req_back = 1'b0;
    logic       req_stay = 1'b0;
    logic [4:0] act_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    scanpath_ctl_fsm i_scanpath_ctl_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .scan_in    (scan_in),
        .sel_branch (sel_branch),
        .req_back   (req_back),
        .req_stay   (req_stay),
        .act_o      (act_o)
    );

    // Row: {code[2:0], x={sel_branch,req_back,req_stay}, act now, probe1, probe2}.
    // Probe inputs sel_branch=1 req_back=1 req_stay=0 give per state:
    // start 00011, branch 01000, pass 00000, decide 11000, return 10000, unused 00000.
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {3'b001, 3'b000, 5'b00011, 5'b01000, 5'b11000},  // R5
        {3'b010, 3'b100, 5'b01000, 5'b11000, 5'b00000},  // R6 taken
        {3'b010, 3'b000, 5'b00100, 5'b00000, 5'b10000},  // R6 not taken
        {3'b011, 3'b111, 5'b00000, 5'b10000, 5'b00011},  // R7
        {3'b100, 3'b011, 5'b11000, 5'b00000, 5'b10000},  // R8 priority
        {3'b100, 3'b001, 5'b00000, 5'b11000, 5'b00000},  // R8 hold
        {3'b100, 3'b000, 5'b00100, 5'b10000, 5'b00011},  // R8 fall-through
        {3'b101, 3'b000, 5'b10000, 5'b00011, 5'b01000},  // R9
        {3'b000, 3'b111, 5'b00000, 5'b00011, 5'b01000},  // R10
        {3'b110, 3'b010, 5'b00000, 5'b00011, 5'b01000},  // R10
        {3'b111, 3'b100, 5'b00000, 5'b00011, 5'b01000},  // R10
        {3'b001, 3'b111, 5'b00011, 5'b01000, 5'b11000},  // R5 inputs ignored
        {3'b101, 3'b111, 5'b10000, 5'b00011, 5'b01000}   // R9 inputs ignored
    };

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'b001:  return "R5";
            3'b010:  return "R6";
            3'b011:  return "R7";
            3'b100:  return "R8";
            3'b101:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [4:0] exp);
        @(negedge clk);
        n_cmp++;
        if (act_o !== exp) begin
            n_bad++;
            $display("FAIL %s: act_o=%b expected %b", req, act_o, exp);
        end
    endtask

    task automatic set_probe();
        sel_branch = 1'b1;
        req_back   = 1'b1;
        req_stay   = 1'b0;
    endtask

    // Shift a code in MSB first with run_en low (R4, R2).
    task automatic scan_load(input logic [2:0] code);
        run_en = 1'b0;
        for (int i = 2; i >= 0; i--) begin
            scan_in = code[i];
            tick();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset state: R1
        set_probe();
        tick();
        tick();
        rst_n = 1'b1;
        check("R1", 5'b00011);
        tick();
        check("R1", 5'b01000);  // start -> branch after one run edge

        // Table walk: scan load, actions live in scan mode, then two run edges.
        for (int v = 0; v < NV; v++) begin
            logic [2:0] code;
            code = VEC[v][20:18];
            scan_load(code);
            {sel_branch, req_back, req_stay} = VEC[v][17:15];
            check({req_of(code), "/R11/R2"}, VEC[v][14:10]);
            run_en = 1'b1;
            tick();
            set_probe();
            check({req_of(code), "/R3"}, VEC[v][9:5]);
            tick();
            check({req_of(code), "/R3"}, VEC[v][4:0]);
        end

        // R4: a fourth shift pushes bit 2 out; 101 then 0 gives 010.
        scan_load(3'b101);
        scan_in = 1'b0;
        tick();
        set_probe();
        check("R4", 5'b01000);

        // R4 then R10: 011 shifted with 1 gives unused 111, silent, then start.
        scan_load(3'b011);
        scan_in = 1'b1;
        tick();
        check("R4", 5'b00000);
        run_en = 1'b1;
        tick();
        check("R10", 5'b00011);

        // R1: reset wins over scan mode.
        scan_load(3'b100);
        check("R1", 5'b11000);
        scan_in = 1'b1;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        run_en = 1'b1;
        check("R1", 5'b00011);

        // R11: actions change with inputs inside one cycle, no edge needed.
        scan_load(3'b010);
        sel_branch = 1'b0;
        check("R11", 5'b00100);
        sel_branch = 1'b1;
        #1;
        n_cmp++;
        if (act_o !== 5'b01000) begin
            n_bad++;
            $display("FAIL R11: act_o=%b expected %b", act_o, 5'b01000);
        end
        run_en = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule